// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Datapath

This block models the storage and datapath of a synchronous static RAM with nine-bit byte lanes. Every control is captured on the rising clock edge: the word address (supplied by an external burst generator), three chip enables, the per-lane and global write controls, and the write data. The stored word then comes back on the read port at one of two fixed latencies. A static mode pin picks the latency. In flow-through mode the array output goes straight to the pins in the cycle after the capturing edge, which gives 2-1-1-1 burst timing. In pipelined mode it passes through one more register on the rising edge, which gives 3-1-1-1 timing.

A capture register classifies each cycle into one of four named states. IDLE is a deselect. READ is a selected cycle with no write request. WRITE is a selected cycle with a lane write or a global write request. SLEEP is any cycle with the sleep input high. Every state can move to every other state on each edge. Priority is fixed: the sleep input sends the next state to SLEEP; otherwise a deselect sends it to IDLE; otherwise a write request sends it to WRITE; otherwise the next state is READ.

The output stage has two named states. EMPTY moves to FULL on an edge where the capture state is READ. Any other capture state moves it back to EMPTY. In pipelined mode this stage supplies the held word and its drive qualifier. A deselect has no tail stage of its own. The pins go quiet on the first edge at which a read would have presented data. The output enable and the sleep input gate the drive qualifier without waiting for a clock. Stored words are kept while asleep.

Top module: `sram_dp`

## Requirements
- R1: The block is selected only when `ce_n`=0, `ce_a`=1 and `ce_b`=1 are all sampled together. Any other combination is a deselect: it writes nothing and produces no read data, whatever the write controls are.
- R2: With `pipe_mode`=0, a read captured at edge n drives `rdata_drive`=1 after edge n. It shows the stored word at the captured address for that one cycle.
- R3: With `pipe_mode`=1, a read captured at edge n drives the stored word after edge n+1 for one cycle. Back-to-back reads present one word per cycle.
- R4: A deselect captured at edge n turns the drive off after edge n in flow-through mode and after edge n+1 in pipelined mode. In pipelined mode, the data of a read captured at edge n-1 is still shown after edge n.
- R5: A lane write (`lane_wr_en`=1, `all_wr`=0) updates lane i, bits [9i+8:9i], only where `lane_sel[i]`=1. Lanes with `lane_sel[i]`=0 keep their contents. With no lane selected, nothing is written.
- R6: `all_wr`=1 in a selected cycle writes every lane, whatever `lane_sel` and `lane_wr_en` are.
- R7: A write cycle never drives the read port. A read captured in the cycle after a write to the same address returns the new data, in both modes.
- R8: `oe`=0 forces `rdata_drive` to 0 at once, without a clock edge. Raising `oe` again restores the drive of a read that is still pending.
- R9: `sleep`=1 forces `rdata_drive` to 0 at once. A cycle captured with `sleep`=1 writes nothing. Stored words survive the sleep period. In pipelined mode it also suppresses the output of the read captured one cycle earlier.
- R10: `rdata` is all zeros whenever `rdata_drive` is 0.
- R11: While `rst_n`=0 and after its release, the drive stays off until a read arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address from the burst generator |
| ce_n | input | 1 | Chip enable, active low |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| lane_wr_en | input | 1 | Lane write request, qualified by lane_sel |
| lane_sel | input | LANES | Per-lane write select |
| all_wr | input | 1 | Global write of every lane |
| wdata | input | LANES*LANE_W | Write data, captured with the address |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through read |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Low-power request; blocks writes and drive |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_drive | output | 1 | Read port is being driven with valid data |

## Verification
In pipelined mode, the presentation of one read's data falls in the same cycle as the capture of the next command. That command can be another read, a write, a deselect or a sleep request. The bench provokes this by issuing a read and, in the very next cycle, each of those commands in turn. The scoreboard expects the earlier read's word in that cycle for a read, a write or a deselect. It expects a quiet port only when sleep was asserted. The same pairing in flow-through mode is expected to end the drive at once. A second overlap tested is an asynchronous output-enable or sleep change in the middle of a cycle that is presenting read data. It is judged by sampling the pins a fraction of a nanosecond after the change.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

    // Classification of one captured input cycle
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2,
        SLOT_SLEEP = 2'd3
    } slot_e;

    // State of the output register stage
    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } ostage_e;

endpackage

// File: rtl/sram_dp_ctrl.sv
module sram_dp_ctrl
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ce_n,
    input  logic                      ce_a,
    input  logic                      ce_b,
    input  logic                      lane_wr_en,
    input  logic [LANES-1:0]          lane_sel,
    input  logic                      all_wr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic                      sleep,
    output slot_e                     slot_q,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES*LANE_W-1:0]   wdata_q,
    output logic [LANES-1:0]          mask_q
);

    localparam int DATA_W = LANES * LANE_W;

    slot_e            slot_d;
    logic             chip_sel;
    logic             wr_req;
    logic [LANES-1:0] mask_d;

    assign chip_sel = !ce_n && ce_a && ce_b;
    assign wr_req   = all_wr || lane_wr_en;

    // Next-state decode: sleep, then deselect, then write, then read
    always_comb begin
        slot_d = SLOT_IDLE;
        unique casez ({sleep, chip_sel, wr_req})
            3'b1??:  slot_d = SLOT_SLEEP;
            3'b00?:  slot_d = SLOT_IDLE;
            3'b010:  slot_d = SLOT_READ;
            3'b011:  slot_d = SLOT_WRITE;
            default: slot_d = SLOT_IDLE;
        endcase
    end

    // Lane mask: global write overrides the per-lane selects
    always_comb begin
        if (all_wr) begin
            mask_d = '1;
        end else if (lane_wr_en) begin
            mask_d = lane_sel;
        end else begin
            mask_d = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SLOT_IDLE;
        end else begin
            slot_q <= slot_d;
        end
    end

    // Captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            addr_q  <= addr;
            wdata_q <= wdata;
            mask_q  <= (slot_d == SLOT_WRITE) ? mask_d : '0;
        end
    end

    // R1
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (ce_n || !ce_a || !ce_b)) |=> (slot_q == SLOT_IDLE && mask_q == '0));

    // R6
    all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ce_n && ce_a && ce_b && all_wr) |=> (&mask_q));

    // R9
    sleep_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (mask_q == '0 && slot_q == SLOT_SLEEP));

    initial begin
        if (DATA_W != LANES * LANE_W) $error("lane geometry mismatch");
    end

endmodule

// File: rtl/sram_dp_array.sv
module sram_dp_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Self-timed commit of the lane captured one edge earlier
        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];

        // R5
        lane_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_mask[g] |=> ((rd_addr != $past(wr_addr)) ||
                            (rd_data[g*LANE_W +: LANE_W] == $past(wr_data[g*LANE_W +: LANE_W]))));
    end

endmodule

// File: rtl/sram_dp_out.sv
module sram_dp_out
    import sram_dp_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic              sleep,
    input  slot_e             slot_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);

    ostage_e           ost_q;
    ostage_e           ost_d;
    logic [DATA_W-1:0] hold_q;
    logic              slot_reads;
    logic              word_valid;

    // Output decode of the captured cycle
    always_comb begin
        slot_reads = 1'b0;
        unique case (slot_q)
            SLOT_READ:  slot_reads = 1'b1;
            SLOT_WRITE: slot_reads = 1'b0;
            SLOT_IDLE:  slot_reads = 1'b0;
            SLOT_SLEEP: slot_reads = 1'b0;
            default:    slot_reads = 1'b0;
        endcase
    end

    assign ost_d = slot_reads ? OUT_FULL : OUT_EMPTY;

    // Output-stage state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ost_q <= OUT_EMPTY;
        end else begin
            ost_q <= ost_d;
        end
    end

    always_ff @(posedge clk) begin
        if (slot_reads) begin
            hold_q <= rd_data;
        end
    end

    // Outputs: mode mux, then asynchronous gating
    always_comb begin
        unique case (ost_q)
            OUT_FULL:  word_valid = pipe_mode ? 1'b1 : slot_reads;
            OUT_EMPTY: word_valid = pipe_mode ? 1'b0 : slot_reads;
            default:   word_valid = 1'b0;
        endcase
        rdata_drive = oe && !sleep && word_valid;
        if (!rdata_drive) begin
            rdata = '0;
        end else if (pipe_mode) begin
            rdata = hold_q;
        end else begin
            rdata = rd_data;
        end
    end

    // R8
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!rdata_drive && rdata == '0));

    // R2
    flow_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rdata_drive) |-> (slot_q == SLOT_READ && rdata == rd_data));

    // R3
    pipe_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && rdata_drive) |->
            ($past(slot_q) == SLOT_READ && rdata == $past(rd_data)));

    // R7
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && slot_q == SLOT_WRITE) |-> !rdata_drive);

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_drive);

endmodule

// File: rtl/sram_dp.sv
module sram_dp
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ce_n,
    input  logic                      ce_a,
    input  logic                      ce_b,
    input  logic                      lane_wr_en,
    input  logic [LANES-1:0]          lane_sel,
    input  logic                      all_wr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic                      pipe_mode,
    input  logic                      oe,
    input  logic                      sleep,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rdata_drive
);

    localparam int DATA_W = LANES * LANE_W;

    slot_e             slot_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] arr_rd;

    sram_dp_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .ce_n       (ce_n),
        .ce_a       (ce_a),
        .ce_b       (ce_b),
        .lane_wr_en (lane_wr_en),
        .lane_sel   (lane_sel),
        .all_wr     (all_wr),
        .wdata      (wdata),
        .sleep      (sleep),
        .slot_q     (slot_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .mask_q     (mask_q)
    );

    sram_dp_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (addr_q),
        .wr_data (wdata_q),
        .wr_mask (mask_q),
        .rd_addr (addr_q),
        .rd_data (arr_rd)
    );

    sram_dp_out #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pipe_mode   (pipe_mode),
        .oe          (oe),
        .sleep       (sleep),
        .slot_q      (slot_q),
        .rd_data     (arr_rd),
        .rdata       (rdata),
        .rdata_drive (rdata_drive)
    );

    // R10
    zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_drive |-> (rdata == '0));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !rdata_drive);

endmodule

// File: tb/sram_dp_test.sv
`timescale 1ns/1ps
module sram_dp_test;

    localparam int AW = 8;
    localparam int NL = 2;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          ce_a = 1'b0;
    logic          ce_b = 1'b0;
    logic          lane_wr_en = 1'b0;
    logic [NL-1:0] lane_sel = '0;
    logic          all_wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          pipe_mode = 1'b0;
    logic          oe = 1'b1;
    logic          sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    always #2.5 clk = ~clk;

    sram_dp #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce_a(ce_a), .ce_b(ce_b),
        .lane_wr_en(lane_wr_en), .lane_sel(lane_sel), .all_wr(all_wr), .wdata(wdata),
        .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    typedef struct {
        int            obs;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] ref_mem [1 << AW];
    int            cyc = 0;
    int            vec = 0;
    int            bad = 0;
    bit            mon_en = 1'b1;

    task automatic chk(input bit ok, input string req,
                       input logic [DW:0] act, input logic [DW:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: compares the port against the scoreboard each cycle
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1.5;
            if (mon_en) begin
                while (sbq.size() > 0 && sbq[0].obs < cyc) begin
                    exp_t stale;
                    stale = sbq.pop_front();
                    chk(1'b0, {stale.req, " missed"}, '0, {1'b1, stale.data});
                end
                if (sbq.size() > 0 && sbq[0].obs == cyc) begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(rdata_drive && rdata == e.data, e.req,
                        {rdata_drive, rdata}, {1'b1, e.data});
                end else begin
                    chk(!rdata_drive && rdata == '0, "R10 R11 R4 R7 quiet port",
                        {rdata_drive, rdata}, '0);
                end
            end
        end
    end

    // Driver: applies one cycle of inputs and predicts its result
    task automatic issue(input logic cn, input logic ca, input logic cb,
                         input logic bwe, input logic gw, input logic [NL-1:0] sel,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit slp, input string req);
        int n;
        @(negedge clk);
        n = cyc + 1;
        ce_n = cn; ce_a = ca; ce_b = cb;
        lane_wr_en = bwe; all_wr = gw; lane_sel = sel;
        addr = a; wdata = d; sleep = slp;
        if (slp) begin
            if (sbq.size() > 0 && sbq[$].obs == n) void'(sbq.pop_back());
        end else if (!cn && ca && cb) begin
            if (gw || bwe) begin
                for (int i = 0; i < NL; i++) begin
                    if (gw || sel[i]) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
                end
            end else begin
                sbq.push_back('{pipe_mode ? n + 1 : n, ref_mem[a], req});
            end
        end
    endtask

    task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] sel);
        issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, sel, a, d, 1'b0, "R6");
    endtask

    task automatic wr_lane(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] sel);
        issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, sel, a, d, 1'b0, "R5");
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, a, '0, 1'b0, req);
    endtask

    task automatic desel(input logic cn, input logic ca, input logic cb, input logic [AW-1:0] a);
        issue(cn, ca, cb, 1'b1, 1'b1, '1, a, 18'h3FFFF, 1'b0, "R1");
    endtask

    task automatic nap(input logic [AW-1:0] a);
        issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, a, 18'h2AAAA, 1'b1, "R9");
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, "R4");
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(32'h15A5A ^ (i * 32'h0B3D7));
    endfunction

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rdata_drive && rdata == '0, "R11 reset", {rdata_drive, rdata}, '0);
        rst_n = 1'b1;
        idle(2);

        // ---- flow-through phase ----
        for (int i = 0; i < 8; i++) wr_all(AW'(i), pat(i), 2'b00);   // R6: selects ignored
        for (int i = 0; i < 8; i++) rd(AW'(i), "R2 flow burst");
        idle(2);                                                     // R4 flow deselect

        wr_lane(8'd3, 18'h1FFFF, 2'b01);                              // R5 lane 0 only
        wr_lane(8'd4, 18'h0F0F0, 2'b10);                              // R5 lane 1 only
        wr_lane(8'd5, 18'h3FFFF, 2'b00);                              // R5 no lane
        rd(8'd3, "R5 lane0"); rd(8'd4, "R5 lane1"); rd(8'd5, "R5 none");
        idle(1);

        wr_all(8'd7, 18'h12345, 2'b01); rd(8'd7, "R7 flow read-after-write");
        rd(8'd1, "R2"); wr_all(8'd2, 18'h2BEEF, 2'b10); rd(8'd2, "R7 write gap");
        idle(1);

        desel(1'b1, 1'b1, 1'b1, 8'd0);
        desel(1'b0, 1'b0, 1'b1, 8'd0);
        desel(1'b0, 1'b1, 1'b0, 8'd0);
        rd(8'd0, "R1 contents kept");
        nap(8'd1); nap(8'd1);
        rd(8'd1, "R9 flow sleep kept");
        idle(2);

        // Asynchronous gating mid-cycle (flow-through)
        mon_en = 1'b0;
        @(negedge clk);
        ce_n = 1'b0; ce_a = 1'b1; ce_b = 1'b1; lane_wr_en = 1'b0; all_wr = 1'b0; addr = 8'd3;
        @(posedge clk); #1;
        chk(rdata_drive && rdata == ref_mem[3], "R2 flow presented", {rdata_drive, rdata}, {1'b1, ref_mem[3]});
        oe = 1'b0; #0.2;
        chk(!rdata_drive && rdata == '0, "R8 oe off", {rdata_drive, rdata}, '0);
        oe = 1'b1; #0.2;
        chk(rdata_drive && rdata == ref_mem[3], "R8 oe restore", {rdata_drive, rdata}, {1'b1, ref_mem[3]});
        sleep = 1'b1; #0.2;
        chk(!rdata_drive && rdata == '0, "R9 sleep async", {rdata_drive, rdata}, '0);
        sleep = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; ce_a = 1'b0; ce_b = 1'b0;
        @(posedge clk); #1;
        chk(!rdata_drive, "R4 flow deselect", {rdata_drive, rdata}, '0);
        @(negedge clk);
        mon_en = 1'b1;

        // ---- pipelined phase ----
        @(negedge clk); pipe_mode = 1'b1;
        idle(2);
        for (int i = 0; i < 4; i++) rd(AW'(i), "R3 pipe burst");
        desel(1'b1, 1'b0, 1'b0, 8'd0);                                // R4 last word still shown
        idle(1);
        rd(8'd4, "R3 then write"); wr_all(8'd5, 18'h0ACE1, 2'b00);
        rd(8'd5, "R7 pipe read-after-write");
        rd(8'd6, "R3 then sleep"); nap(8'd6);                         // R9 suppresses obs
        rd(8'd6, "R9 pipe sleep kept");
        wr_lane(8'd2, 18'h3C3C3, 2'b10); rd(8'd2, "R5 pipe lane1");
        rd(8'd7, "R3 single");
        idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule